// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Byte-Access Controller

This block is a hardware master for a three-wire serial EEPROM that stores 64 words of 16 bits. The host sees the memory as a flat array of 128 bytes. A request gives a start byte offset, a byte count and a direction. The bytes then move through a valid/ready stream: an outbound stream for reads and an inbound stream for writes. The request finishes with a one-cycle done pulse, and an error flag travels with that pulse.

The controller drives chip select, serial clock and serial data toward the device, and it samples the device's serial data output. Because the device stores words, each byte is mapped onto a word and a lane. A byte write reads the containing word, replaces one lane and writes the whole word back. A write request is framed by an enable-writes command at its start and a disable-writes command at its end. Every word write is followed by a ready poll that has a cycle limit. Bit timing comes from a prescaler parameter: each clock phase lasts `PRESCALE` system clocks.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While idle (`req_ready` high), `ee_cs`, `ee_sck` and `ee_din` are all low, and after reset the block is idle with `done` low.
- R2: A request with offset of 128 or more, or with offset plus count above 128, ends with `done` and `error` both high, and chip select never rises.
- R3: A read returns `count` bytes in ascending offset order. Byte offset b comes from word b/2: bits 15:8 when b is odd, bits 7:0 when b is even.
- R4: Every command frame starts with a 1 bit, then a 2-bit opcode, then the 6-bit word address, all MSB first. READ is 10 and carries the data word read from the device; WRITE is 01 and is followed by 16 data bits MSB first. The address of both is the byte offset divided by two.
- R5: `ee_din` never changes while `ee_sck` is high.
- R6: Every high phase and every low phase of `ee_sck` within a frame lasts at least `PRESCALE` clocks, and every high phase lasts exactly `PRESCALE` clocks.
- R7: A write request of n bytes issues exactly 2n+2 frames. The first is enable-writes (opcode 00, address 11xxxx), and the last is disable-writes (opcode 00, address 00xxxx).
- R8: A byte write reads the containing word, then writes back the word with the new byte in its lane and the other lane unchanged.
- R9: After each word write, chip select drops and then rises again. The block waits on `ee_dout` high before it continues. If `ee_dout` stays low for `POLL_LIMIT` clocks, the request ends with `error` and no disable-writes frame.
- R10: `ee_sck` is never high while `ee_cs` is low.
- R11: A request with count 0 and a legal offset ends with `done` high and `error` low, and no frame is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; accepts a request |
| req_write | input | 1 | 1 = write bytes, 0 = read bytes |
| req_offset | input | 8 | First byte offset |
| req_count | input | 8 | Number of bytes |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Controller takes the write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Request failed; valid with done |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sck | output | 1 | Device serial clock |
| ee_din | output | 1 | Serial data to the device |
| ee_dout | input | 1 | Serial data from the device |

## Verification
On a read, the host's acceptance of a byte and the launch of the next word-read frame happen in the same cycle. The offset increment chosen in that cycle also decides the word address of the next frame and the lane that is selected. The bench holds `rd_ready` low on random cycles so that this hand-off lands at varying points, and it sends bursts that cross word boundaries from both odd and even start offsets. It judges the result by comparing every returned byte, and every READ frame address seen by its device model, against a shadow byte array.

// File: rtl/mw_pkg.sv
// Package: shared opcode constants and state encodings for the serial EEPROM controller.
// Assumes a device command of start bit, 2-bit opcode and word address.
package mw_pkg;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    typedef enum logic [2:0] {
        E_IDLE, E_SETUP, E_HIGH, E_TAIL, E_GAP
    } eng_st_e;

    typedef enum logic [3:0] {
        S_IDLE, S_EWEN, S_WGET, S_RD, S_ROUT, S_WR, S_POLL, S_GAP, S_EWDS, S_FIN
    } ctl_st_e;

endpackage

// File: rtl/mw_bit_engine.sv
// Bit engine: sends one chip-select frame of up to FRAME_W bits, MSB first.
// It raises chip select, waits one phase, then for each bit holds data with the
// clock low for PRESCALE clocks and with the clock high for PRESCALE clocks.
// The device output is sampled on the rising clock edge. The frame ends with a
// low tail phase, chip select low, and a gap phase before done.
// Assumes start is pulsed only while the engine is idle; rx keeps the last DATA_W samples.
module mw_bit_engine
    import mw_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int FRAME_W  = 25,
    parameter int DATA_W   = 16,
    localparam int NB_W    = $clog2(FRAME_W + 1),
    localparam int PH_W    = $clog2(PRESCALE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NB_W-1:0]    nbits,
    input  logic [FRAME_W-1:0] tx,
    input  logic               dout,
    output logic               cs,
    output logic               sck,
    output logic               din,
    output logic               done,
    output logic [DATA_W-1:0]  rx
);

    eng_st_e            st;
    logic [PH_W-1:0]    ph;
    logic [NB_W-1:0]    left;
    logic [FRAME_W-1:0] sh;
    logic               ph_end;

    assign ph_end = (ph == PH_W'(PRESCALE - 1));

    // Frame sequencer: phase timing, bit shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= E_IDLE;
            ph   <= '0;
            left <= '0;
            sh   <= '0;
            cs   <= 1'b0;
            sck  <= 1'b0;
            din  <= 1'b0;
            done <= 1'b0;
            rx   <= '0;
        end else begin
            done <= 1'b0;
            ph   <= ph_end ? '0 : ph + 1'b1;
            case (st)
                E_IDLE: begin
                    ph <= '0;
                    if (start) begin
                        cs   <= 1'b1;
                        din  <= tx[FRAME_W-1];
                        sh   <= {tx[FRAME_W-2:0], 1'b0};
                        left <= nbits;
                        st   <= E_SETUP;
                    end
                end
                E_SETUP: if (ph_end) begin
                    sck <= 1'b1;
                    rx  <= {rx[DATA_W-2:0], dout};
                    st  <= E_HIGH;
                end
                E_HIGH: if (ph_end) begin
                    sck <= 1'b0;
                    if (left == NB_W'(1)) begin
                        din <= 1'b0;
                        st  <= E_TAIL;
                    end else begin
                        din  <= sh[FRAME_W-1];
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                        left <= left - 1'b1;
                        st   <= E_SETUP;
                    end
                end
                E_TAIL: if (ph_end) begin
                    cs <= 1'b0;
                    st <= E_GAP;
                end
                E_GAP: if (ph_end) begin
                    done <= 1'b1;
                    st   <= E_IDLE;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mw_lane.sv
// Lane unit: picks the addressed byte out of a word and builds the word that
// carries a replacement byte in that lane. Odd offsets use the upper lane.
// Purely combinational.
module mw_lane #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              hi,
    input  logic [BYTE_W-1:0] new_byte,
    output logic [BYTE_W-1:0] byte_out,
    output logic [WORD_W-1:0] merged
);

    // Lane select and lane replace.
    always_comb begin
        byte_out = hi ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
        merged   = hi ? {new_byte, word[BYTE_W-1:0]} : {word[WORD_W-1:BYTE_W], new_byte};
    end

endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Controller top: maps byte requests onto a word-organised three-wire EEPROM.
// Reads issue one READ frame per byte. Writes are framed by enable/disable
// commands, and each byte does read-modify-write of its word followed by a
// ready poll with a POLL_LIMIT-clock timeout. Out-of-range requests are
// rejected without touching the device.
// Assumes the host holds request fields stable while req_valid is high.
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int PRESCALE   = 4,
    parameter int POLL_LIMIT = 4096,
    localparam int OFF_W     = ADDR_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [OFF_W-1:0] req_count,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             error,
    output logic             ee_cs,
    output logic             ee_sck,
    output logic             ee_din,
    input  logic             ee_dout
);

    localparam int WORDS   = 1 << ADDR_W;
    localparam int BYTES   = 2 * WORDS;
    localparam int HDR_W   = ADDR_W + 3;
    localparam int FRAME_W = HDR_W + 16;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int CT_W    = $clog2(POLL_LIMIT + PRESCALE + 1);

    ctl_st_e            st;
    logic [OFF_W-1:0]   off, left, nxt_off;
    logic               is_wr, err_q, poll_cs;
    logic [7:0]         wbyte;
    logic [CT_W-1:0]    cnt;
    logic               eng_start, eng_cs, eng_done;
    logic [NB_W-1:0]    eng_nbits;
    logic [FRAME_W-1:0] eng_tx;
    logic [15:0]        eng_rx, merged;
    logic [OFF_W:0]     req_end;
    logic               req_bad;

    // Build one frame: start bit, opcode, address, data.
    function automatic logic [FRAME_W-1:0] mk_frame(logic [1:0] op, logic [ADDR_W-1:0] a,
                                                   logic [15:0] d);
        return {1'b1, op, a, d};
    endfunction

    localparam logic [ADDR_W-1:0] A_EWEN = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] A_EWDS = '0;

    assign nxt_off = off + 1'b1;
    assign req_end = {1'b0, req_offset} + {1'b0, req_count};
    assign req_bad = (req_offset >= OFF_W'(BYTES)) || (req_end > (OFF_W+1)'(BYTES));

    assign req_ready = (st == S_IDLE);
    assign wr_ready  = (st == S_WGET);
    assign rd_valid  = (st == S_ROUT);
    assign done      = (st == S_FIN);
    assign error     = done & err_q;
    assign ee_cs     = eng_cs | poll_cs;

    mw_bit_engine #(.PRESCALE(PRESCALE), .FRAME_W(FRAME_W), .DATA_W(16)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .nbits(eng_nbits), .tx(eng_tx),
        .dout(ee_dout), .cs(eng_cs), .sck(ee_sck), .din(ee_din), .done(eng_done),
        .rx(eng_rx)
    );

    mw_lane #(.BYTE_W(8)) u_lane (
        .word(eng_rx), .hi(off[0]), .new_byte(wbyte), .byte_out(rd_data), .merged(merged)
    );

    // Request sequencer: command order, byte stepping, polling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            off       <= '0;
            left      <= '0;
            is_wr     <= 1'b0;
            err_q     <= 1'b0;
            poll_cs   <= 1'b0;
            wbyte     <= '0;
            cnt       <= '0;
            eng_start <= 1'b0;
            eng_nbits <= '0;
            eng_tx    <= '0;
        end else begin
            eng_start <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    off   <= req_offset;
                    left  <= req_count;
                    is_wr <= req_write;
                    err_q <= req_bad;
                    if (req_bad || req_count == '0) begin
                        st <= S_FIN;
                    end else if (req_write) begin
                        eng_start <= 1'b1;
                        eng_nbits <= NB_W'(HDR_W);
                        eng_tx    <= mk_frame(OPC_EXT, A_EWEN, 16'h0);
                        st        <= S_EWEN;
                    end else begin
                        eng_start <= 1'b1;
                        eng_nbits <= NB_W'(FRAME_W);
                        eng_tx    <= mk_frame(OPC_READ, req_offset[ADDR_W:1], 16'h0);
                        st        <= S_RD;
                    end
                end
                S_EWEN: if (eng_done) st <= S_WGET;
                S_WGET: if (wr_valid) begin
                    wbyte     <= wr_data;
                    eng_start <= 1'b1;
                    eng_nbits <= NB_W'(FRAME_W);
                    eng_tx    <= mk_frame(OPC_READ, off[ADDR_W:1], 16'h0);
                    st        <= S_RD;
                end
                S_RD: if (eng_done) begin
                    if (is_wr) begin
                        eng_start <= 1'b1;
                        eng_nbits <= NB_W'(FRAME_W);
                        eng_tx    <= mk_frame(OPC_WRITE, off[ADDR_W:1], merged);
                        st        <= S_WR;
                    end else begin
                        st <= S_ROUT;
                    end
                end
                S_ROUT: if (rd_ready) begin
                    off  <= nxt_off;
                    left <= left - 1'b1;
                    if (left == OFF_W'(1)) begin
                        st <= S_FIN;
                    end else begin
                        eng_start <= 1'b1;
                        eng_nbits <= NB_W'(FRAME_W);
                        eng_tx    <= mk_frame(OPC_READ, nxt_off[ADDR_W:1], 16'h0);
                        st        <= S_RD;
                    end
                end
                S_WR: if (eng_done) begin
                    poll_cs <= 1'b1;
                    cnt     <= '0;
                    st      <= S_POLL;
                end
                S_POLL: begin
                    cnt <= cnt + 1'b1;
                    if (ee_dout) begin
                        poll_cs <= 1'b0;
                        cnt     <= '0;
                        st      <= S_GAP;
                    end else if (cnt == CT_W'(POLL_LIMIT - 1)) begin
                        poll_cs <= 1'b0;
                        err_q   <= 1'b1;
                        st      <= S_FIN;
                    end
                end
                S_GAP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CT_W'(PRESCALE - 1)) begin
                        off  <= nxt_off;
                        left <= left - 1'b1;
                        if (left == OFF_W'(1)) begin
                            eng_start <= 1'b1;
                            eng_nbits <= NB_W'(HDR_W);
                            eng_tx    <= mk_frame(OPC_EXT, A_EWDS, 16'h0);
                            st        <= S_EWDS;
                        end else begin
                            st <= S_WGET;
                        end
                    end
                end
                S_EWDS: if (eng_done) st <= S_FIN;
                S_FIN: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
// Checker: port-level timing and handshake properties of the controller.
// Bound to every instance of mw_eeprom_ctrl.
module mw_eeprom_chk #(
    parameter int PRESCALE = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ee_cs,
    input logic ee_sck,
    input logic ee_din,
    input logic req_ready,
    input logic done,
    input logic error
);

    logic        sck_q;
    logic [15:0] held;

    // Count how long the serial clock has held its present level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            held  <= '0;
        end else begin
            sck_q <= ee_sck;
            if (ee_sck != sck_q) held <= 16'd1;
            else if (held != 16'hFFFF) held <= held + 16'd1;
        end
    end

    p_phase_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sck != sck_q) |-> (held >= 16'(PRESCALE)));

    p_din_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sck |-> $stable(ee_din));

    p_sck_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sck);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ee_cs && !ee_sck && !ee_din));

    p_err_in_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    p_done_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

endmodule

bind mw_eeprom_ctrl mw_eeprom_chk #(.PRESCALE(PRESCALE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_din(ee_din),
    .req_ready(req_ready), .done(done), .error(error)
);

// File: tb/mw_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_tb;

    localparam int P  = 2;
    localparam int PL = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       req_valid = 0, req_write = 0, wr_valid = 0, rd_ready = 0;
    logic [7:0] req_offset = 0, req_count = 0, wr_data = 0;
    logic       req_ready, wr_ready, rd_valid, done, error, ee_cs, ee_sck, ee_din, ee_dout;
    logic [7:0] rd_data;

    mw_eeprom_ctrl #(.ADDR_W(6), .PRESCALE(P), .POLL_LIMIT(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_offset(req_offset), .req_count(req_count),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .error(error), .ee_cs(ee_cs), .ee_sck(ee_sck),
        .ee_din(ee_din), .ee_dout(ee_dout)
    );

    // ---------------- device model (runs on the falling system clock) --------
    logic [15:0] mem [0:63];
    logic [8:0]  cmd_sh = 0;
    logic [15:0] wd = 0, rdw = 0;
    logic [5:0]  cur_a = 0;
    logic        wen = 0, polling = 0, do_r = 0, loaded = 0;
    logic        sk_p = 0, cs_p = 0, di_p = 0;
    int          bitn = 0, cur_op = 0, busy = 0, hi_len = 0;
    int          busy_len = 20;
    int          ph_err = 0, r5_err = 0, r10_err = 0, cs_rises = 0, op_n = 0;
    int          op_log [0:4095];
    int          addr_log [0:4095];

    assign ee_dout = polling ? (busy == 0) : do_r;

    function automatic logic [15:0] init_word(int i);
        return 16'(i * 7459) ^ 16'hA55A;
    endfunction

    always @(negedge clk) begin
        if (!loaded) begin
            for (int i = 0; i < 64; i++) mem[i] = init_word(i);
            loaded = 1;
        end
        if (busy > 0) busy--;
        if (ee_cs === 1'b1 && cs_p === 1'b0) begin
            bitn = 0; do_r = 0; cur_op = 0; cs_rises++;
        end
        if (ee_sck === 1'b1 && sk_p === 1'b0 && ee_cs === 1'b1) begin
            bitn++;
            polling = 0;
            hi_len = 0;
            cmd_sh = {cmd_sh[7:0], ee_din};
            if (bitn > 9) wd = {wd[14:0], ee_din};
            if (bitn == 9) begin
                cur_a = cmd_sh[5:0];
                if (!cmd_sh[8]) cur_op = 5;
                else case (cmd_sh[7:6])
                    2'b10: begin cur_op = 1; rdw = mem[cmd_sh[5:0]]; end
                    2'b01: cur_op = 2;
                    2'b00: begin
                        if (cmd_sh[5:4] == 2'b11) begin cur_op = 3; wen = 1; end
                        else if (cmd_sh[5:4] == 2'b00) begin cur_op = 4; wen = 0; end
                        else cur_op = 5;
                    end
                    default: cur_op = 5;
                endcase
                op_log[op_n % 4096] = cur_op;
                addr_log[op_n % 4096] = int'(cur_a);
                op_n++;
            end
        end
        if (ee_sck === 1'b1) hi_len++;
        if (ee_sck === 1'b0 && sk_p === 1'b1) begin
            if (hi_len != P) ph_err++;
            if (ee_cs === 1'b1 && cur_op == 1 && bitn >= 9 && bitn < 25) do_r = rdw[24 - bitn];
        end
        if (ee_cs === 1'b0 && cs_p === 1'b1 && cur_op == 2 && bitn == 25) begin
            if (wen) mem[cur_a] = wd;
            busy = busy_len;
            polling = 1;
        end
        if (ee_sck === 1'b1 && sk_p === 1'b1 && ee_din !== di_p) r5_err++;
        if (ee_sck === 1'b1 && ee_cs !== 1'b1) r10_err++;
        sk_p = ee_sck; cs_p = ee_cs; di_p = ee_din;
    end

    // ---------------- bench bookkeeping -------------------------------------
    int         n_chk = 0, n_err = 0;
    bit         hung = 0;
    logic [7:0] exp_b [0:127];
    logic [7:0] wbuf [0:127];
    logic [7:0] rbuf [0:127];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(int b);
        logic [15:0] w;
        w = init_word(b >> 1);
        return b[0] ? w[15:8] : w[7:0];
    endfunction

    // Issue one request and service its stream until done.
    task automatic run_req(input bit w, input int off, input int cnt,
                           output bit err, output int nrd, output int ob, output int cb);
        int guard, widx;
        guard = 0; widx = 0; nrd = 0; err = 0;
        ob = op_n; cb = cs_rises;
        req_write = w; req_offset = off[7:0]; req_count = cnt[7:0]; req_valid = 1;
        while (!req_ready && guard < 30000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 0;
        forever begin
            rd_ready = ($urandom % 4) != 0;
            wr_valid = 1;
            wr_data  = wbuf[widx % 128];
            if (rd_valid && rd_ready) begin rbuf[nrd % 128] = rd_data; nrd++; end
            if (wr_valid && wr_ready) widx++;
            if (done) begin err = error; break; end
            @(negedge clk);
            guard++;
            if (guard > 30000) begin
                hung = 1;
                chk(0, "watchdog", guard, 0);
                break;
            end
        end
        rd_ready = 0; wr_valid = 0;
        @(negedge clk);
    endtask

    task automatic do_read(input int off, input int cnt);
        bit err; int nrd, ob, cb;
        run_req(0, off, cnt, err, nrd, ob, cb);
        chk(err == 0, "R3 read error flag", err, 0);
        chk(nrd == cnt, "R3 byte count", nrd, cnt);
        for (int i = 0; i < cnt && i < nrd; i++)
            chk(rbuf[i] == exp_b[off + i], "R3 byte value", rbuf[i], exp_b[off + i]);
        chk(op_n - ob == cnt, "R4 read frame count", op_n - ob, cnt);
        for (int i = 0; i < cnt && ob + i < op_n; i++) begin
            chk(op_log[(ob + i) % 4096] == 1, "R4 read opcode", op_log[(ob + i) % 4096], 1);
            chk(addr_log[(ob + i) % 4096] == (off + i) >> 1, "R4 read address",
                addr_log[(ob + i) % 4096], (off + i) >> 1);
        end
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < 64; i++)
            if (mem[i] != {exp_b[2*i+1], exp_b[2*i]}) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic do_write(input int off, input int cnt);
        bit err; int nrd, ob, cb, n;
        for (int i = 0; i < cnt; i++) wbuf[i] = 8'($urandom);
        run_req(1, off, cnt, err, nrd, ob, cb);
        n = op_n - ob;
        chk(err == 0, "R9 write completes after ready", err, 0);
        chk(n == 2 * cnt + 2, "R7 frame count", n, 2 * cnt + 2);
        chk(op_log[ob % 4096] == 3, "R7 first frame enable", op_log[ob % 4096], 3);
        chk(op_log[(op_n - 1) % 4096] == 4, "R7 last frame disable", op_log[(op_n - 1) % 4096], 4);
        for (int i = 0; i < cnt && 2 * i + 2 < n; i++) begin
            chk(op_log[(ob + 1 + 2*i) % 4096] == 1 && op_log[(ob + 2 + 2*i) % 4096] == 2,
                "R8 read then write", op_log[(ob + 2 + 2*i) % 4096], 2);
            chk(addr_log[(ob + 2 + 2*i) % 4096] == (off + i) >> 1, "R4 write address",
                addr_log[(ob + 2 + 2*i) % 4096], (off + i) >> 1);
        end
        for (int i = 0; i < cnt; i++) exp_b[off + i] = wbuf[i];
        cmp_mem("R8 memory after write");
    endtask

    task automatic do_reject(input int off, input int cnt, input bit w);
        bit err; int nrd, ob, cb;
        run_req(w, off, cnt, err, nrd, ob, cb);
        chk(err == 1, "R2 rejected error", err, 1);
        chk(cs_rises == cb, "R2 no chip select", cs_rises - cb, 0);
        chk(nrd == 0, "R2 no bytes", nrd, 0);
    endtask

    initial begin
        bit err; int nrd, ob, cb, off, cnt, mx;
        void'($urandom(32'd61357));
        repeat (4) @(negedge clk);
        chk(done === 1'b0 && ee_cs === 1'b0 && ee_sck === 1'b0, "R1 in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 idle ready", req_ready, 1);
        chk(ee_cs === 1'b0 && ee_sck === 1'b0 && ee_din === 1'b0, "R1 idle pins",
            {ee_cs, ee_sck, ee_din}, 0);
        for (int i = 0; i < 128; i++) exp_b[i] = init_byte(i);

        // directed reads: lanes, top byte, word crossings
        do_read(0, 2);
        do_read(127, 1);
        do_read(5, 3);
        do_read(120, 8);
        // range rejections at and past the edge
        do_reject(128, 1, 0);
        do_reject(120, 9, 0);
        do_reject(200, 0, 1);
        do_reject(127, 2, 1);
        // zero count
        run_req(0, 10, 0, err, nrd, ob, cb);
        chk(err == 0 && cs_rises == cb, "R11 zero count", cs_rises - cb, 0);
        run_req(1, 127, 0, err, nrd, ob, cb);
        chk(err == 0 && op_n == ob, "R11 zero count write", op_n - ob, 0);
        // directed writes: odd lane, even lane, last word
        if (!hung) do_write(3, 1);
        if (!hung) do_write(4, 1);
        if (!hung) do_write(126, 2);
        if (!hung) do_read(2, 4);
        // random mix
        for (int k = 0; k < 24 && !hung; k++) begin
            off = $urandom % 128;
            mx = 128 - off;
            if (mx > 6) mx = 6;
            cnt = 1 + ($urandom % mx);
            if (k % 2 == 0) do_write(off, cnt);
            else do_read(off, cnt);
        end
        // poll timeout
        if (!hung) begin
            busy_len = 1000;
            wbuf[0] = 8'h5C;
            run_req(1, 9, 1, err, nrd, ob, cb);
            chk(err == 1, "R9 poll timeout error", err, 1);
            chk(op_n - ob == 3, "R9 no disable after timeout", op_n - ob, 3);
            exp_b[9] = 8'h5C;
            repeat (900) @(negedge clk);
            busy_len = 20;
            do_write(9, 1);
            do_read(8, 2);
        end
        chk(ph_err == 0, "R6 clock high length", ph_err, 0);
        chk(r5_err == 0, "R5 data steady while clock high", r5_err, 0);
        chk(r10_err == 0, "R10 clock only under select", r10_err, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule